// File: doc/BRIEF.md
# Dual-Input Alternating Watchdog Timer

This block supervises one or two processors through two heartbeat lines. After the system reset sequencer asserts the monitor-enable input, the watchdog runs a charge phase of a fixed number of clock cycles. It then runs a discharge phase of its own fixed length. During the discharge phase, software proves it is alive by producing a rising edge on heartbeat A and, at some later point, a rising edge on heartbeat B. That completed pair sends the block back to the charge phase. If the discharge phase runs out first, the block emits a one-cycle timeout pulse, which the surrounding logic turns into a system reset.

Both heartbeat lines are raw, asynchronous levels. Each passes through a two-flop synchronizer before its rising edge is detected. Repeated edges on the same line are ignored while the alternation is incomplete. As a result, a board that ties both lines to one heartbeat gets one proof of life for every two pulses. An inhibit input halts supervision completely. Monitoring starts again from the charge phase whenever inhibit drops or monitor-enable rises. Both phase lengths are parameters counted in clock cycles.

Top module: `dual_hb_watchdog`

## Requirements
- R1: While `rst` is high, and after it is released with `mon_en_i` low, `timeout_o` is 0.
- R2: Only a low-to-high transition of a heartbeat line counts. A line held high counts once, when it rises.
- R3: With no heartbeats, if `mon_en_i` is first seen high at clock edge p0, then `timeout_o` is high for exactly the one cycle following edge p0+CHARGE_CYC+DRAIN_CYC.
- R4: An A-rise followed later by a B-rise, completing during the discharge phase, restarts the charge phase. A steady A-then-B heartbeat therefore never times out.
- R5: B-rises without a preceding accepted A-rise, repeated A-rises, and a B-rise followed by an A-rise do not count as a kick.
- R6: When A and B rise in the same cycle while the block is awaiting A, the A-rise is accepted and the B-rise is dropped. A later B-rise then completes the kick.
- R7: While `inhibit_i` is high, no timeout is produced. When it returns low, a new charge phase starts with the same timing as R3.
- R8: After a timeout the block stays silent until `mon_en_i` is dropped and raised again. A rise of `mon_en_i` starts monitoring afresh from the charge phase.
- R9: With both lines driven by one heartbeat, only every other pulse kicks. A period of 6 cycles never times out, and a period of 14 cycles times out (with CHARGE_CYC=8, DRAIN_CYC=16).
- R10: A kick that completes on the last discharge cycle wins over the timeout. One cycle later it is too late.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hb_a_i | input | 1 | Raw heartbeat A (first in the alternation) |
| hb_b_i | input | 1 | Raw heartbeat B (second in the alternation) |
| inhibit_i | input | 1 | High halts the watchdog |
| mon_en_i | input | 1 | High once the system reset sequence has released |
| timeout_o | output | 1 | One-cycle pulse when the discharge phase expires |

## Verification
The bench drives a correct A-then-B heartbeat, then B-only trains, repeated A trains, a reversed B-then-A pair, simultaneous edges, and held-high levels. Against a correct heartbeat, each of these must separate a proper alternation tracker from one that counts any edge or any level. Tied heartbeats are run at two periods that straddle the R9 limit. This tells an every-other-pulse tracker apart from one that counts each pulse. A B-rise placed on the last discharge cycle, and then one cycle later, pins the kick-versus-timeout priority. Inhibit windows and monitor-enable toggles check that the restart timing is measured from the release.

// File: rtl/hbwd_pkg.sv
package hbwd_pkg;

    typedef enum logic [1:0] {
        PH_IDLE    = 2'd0,
        PH_CHARGE  = 2'd1,
        PH_DRAIN   = 2'd2,
        PH_EXPIRED = 2'd3
    } phase_e;

    typedef enum logic {
        TRK_WANT_A = 1'b0,
        TRK_WANT_B = 1'b1
    } trk_e;

endpackage

// File: rtl/hbwd_sync.sv
module hbwd_sync #(
    parameter int unsigned LANES  = 2,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [LANES-1:0] raw_i,
    output logic [LANES-1:0] rise_o
);

    localparam int unsigned LAST = STAGES - 1;

    typedef struct packed {
        logic [STAGES-1:0][LANES-1:0] pipe;
        logic [LANES-1:0]             prev;
    } sync_t;

    sync_t sync_d, sync_q;

    always_comb begin
        sync_d = sync_q;
        sync_d.pipe[0] = raw_i;
        for (int s = 1; s < STAGES; s++) begin
            sync_d.pipe[s] = sync_q.pipe[s-1];
        end
        sync_d.prev = sync_q.pipe[LAST];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= '0;
        end else begin
            sync_q <= sync_d;
        end
    end

    generate
        for (genvar l = 0; l < LANES; l++) begin : g_lane
            assign rise_o[l] = sync_q.pipe[LAST][l] & ~sync_q.prev[l];

            // R2: a held level yields a single rise indication
            a_r2_rise_single: assert property (@(posedge clk) disable iff (rst)
                rise_o[l] |=> !rise_o[l]);
        end
    endgenerate

endmodule

// File: rtl/hbwd_alt.sv
module hbwd_alt
    import hbwd_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic clr_i,
    input  logic rise_a_i,
    input  logic rise_b_i,
    output logic done_o
);

    typedef struct packed {
        trk_e st;
    } alt_t;

    alt_t alt_d, alt_q;
    logic done_d;

    always_comb begin
        alt_d  = alt_q;
        done_d = 1'b0;
        if (clr_i) begin
            alt_d.st = TRK_WANT_A;
        end else begin
            unique case (alt_q.st)
                TRK_WANT_A: begin
                    if (rise_a_i) begin
                        alt_d.st = TRK_WANT_B;
                    end
                end
                TRK_WANT_B: begin
                    if (rise_b_i) begin
                        alt_d.st = TRK_WANT_A;
                        done_d   = 1'b1;
                    end
                end
                default: alt_d.st = TRK_WANT_A;
            endcase
        end
    end

    assign done_o = done_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            alt_q.st <= TRK_WANT_A;
        end else begin
            alt_q <= alt_d;
        end
    end

    // R6: simultaneous rises while awaiting A accept A only
    a_r6_tie_takes_a: assert property (@(posedge clk) disable iff (rst)
        (!clr_i && alt_q.st == TRK_WANT_A && rise_a_i && rise_b_i)
        |=> (alt_q.st == TRK_WANT_B));

    // R5: further A rises while awaiting B leave the tracker waiting for B
    a_r5_repeat_a_ignored: assert property (@(posedge clk) disable iff (rst)
        (!clr_i && alt_q.st == TRK_WANT_B && !rise_b_i)
        |=> (alt_q.st == TRK_WANT_B));

    // R5: a kick is only ever reported from the awaiting-B state
    a_r5_done_after_a: assert property (@(posedge clk) disable iff (rst)
        done_o |-> (alt_q.st == TRK_WANT_B && rise_b_i));

endmodule

// File: rtl/hbwd_phase.sv
module hbwd_phase
    import hbwd_pkg::*;
#(
    parameter int unsigned CHARGE_CYC = 1000,
    parameter int unsigned DRAIN_CYC  = 4000
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   active_i,
    input  logic   done_i,
    output phase_e phase_o,
    output logic   timeout_o
);

    localparam int unsigned LONGEST = (CHARGE_CYC > DRAIN_CYC) ? CHARGE_CYC : DRAIN_CYC;
    localparam int unsigned CW      = $clog2(LONGEST + 1);
    localparam logic [CW-1:0] CHG_LAST = CW'(CHARGE_CYC - 1);
    localparam logic [CW-1:0] DRN_LAST = CW'(DRAIN_CYC - 1);

    typedef struct packed {
        phase_e        ph;
        logic [CW-1:0] cnt;
        logic          to;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    always_comb begin
        tmr_d    = tmr_q;
        tmr_d.to = 1'b0;
        if (!active_i) begin
            tmr_d.ph  = PH_IDLE;
            tmr_d.cnt = '0;
        end else begin
            unique case (tmr_q.ph)
                PH_IDLE: begin
                    tmr_d.ph  = PH_CHARGE;
                    tmr_d.cnt = '0;
                end
                PH_CHARGE: begin
                    if (tmr_q.cnt == CHG_LAST) begin
                        tmr_d.ph  = PH_DRAIN;
                        tmr_d.cnt = '0;
                    end else begin
                        tmr_d.cnt = tmr_q.cnt + CW'(1);
                    end
                end
                PH_DRAIN: begin
                    if (done_i) begin
                        tmr_d.ph  = PH_CHARGE;
                        tmr_d.cnt = '0;
                    end else if (tmr_q.cnt == DRN_LAST) begin
                        tmr_d.ph  = PH_EXPIRED;
                        tmr_d.cnt = '0;
                        tmr_d.to  = 1'b1;
                    end else begin
                        tmr_d.cnt = tmr_q.cnt + CW'(1);
                    end
                end
                PH_EXPIRED: begin
                    tmr_d.ph = PH_EXPIRED;
                end
                default: begin
                    tmr_d.ph  = PH_IDLE;
                    tmr_d.cnt = '0;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tmr_q.ph  <= PH_IDLE;
            tmr_q.cnt <= '0;
            tmr_q.to  <= 1'b0;
        end else begin
            tmr_q <= tmr_d;
        end
    end

    assign phase_o   = tmr_q.ph;
    assign timeout_o = tmr_q.to;

    // R3: timeout is a single-cycle pulse
    a_r3_pulse_one_cycle: assert property (@(posedge clk) disable iff (rst)
        tmr_q.to |=> !tmr_q.to);

    // R3: a timeout only ever follows the discharge phase
    a_r3_from_drain: assert property (@(posedge clk) disable iff (rst)
        $rose(tmr_q.to) |-> $past(tmr_q.ph == PH_DRAIN));

    // R3: the charge counter stays inside its window
    a_r3_cnt_bound: assert property (@(posedge clk) disable iff (rst)
        (tmr_q.ph == PH_CHARGE) |-> (tmr_q.cnt <= CHG_LAST));

    // R4: a kick during discharge restarts a fresh charge phase
    a_r4_kick_recharges: assert property (@(posedge clk) disable iff (rst)
        (active_i && tmr_q.ph == PH_DRAIN && done_i)
        |=> (tmr_q.ph == PH_CHARGE && tmr_q.cnt == '0 && !tmr_q.to));

    // R7: when halted, no timeout and the block parks in idle
    a_r7_quiet_when_halted: assert property (@(posedge clk) disable iff (rst)
        !active_i |=> (!tmr_q.to && tmr_q.ph == PH_IDLE));

    // R8: once expired the block stays silent while enabled
    a_r8_expired_holds: assert property (@(posedge clk) disable iff (rst)
        (active_i && tmr_q.ph == PH_EXPIRED) |=> (tmr_q.ph == PH_EXPIRED && !tmr_q.to));

endmodule

// File: rtl/dual_hb_watchdog.sv
module dual_hb_watchdog
    import hbwd_pkg::*;
#(
    parameter int unsigned CHARGE_CYC  = 1000,
    parameter int unsigned DRAIN_CYC   = 4000,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic hb_a_i,
    input  logic hb_b_i,
    input  logic inhibit_i,
    input  logic mon_en_i,
    output logic timeout_o
);

    localparam int unsigned HB_LANES = 2;
    localparam int unsigned LANE_A   = 0;
    localparam int unsigned LANE_B   = 1;

    logic [HB_LANES-1:0] hb_raw;
    logic [HB_LANES-1:0] hb_rise;
    logic                active;
    logic                trk_clr;
    logic                kick;
    phase_e              phase;

    assign hb_raw[LANE_A] = hb_a_i;
    assign hb_raw[LANE_B] = hb_b_i;
    assign active         = mon_en_i & ~inhibit_i;
    assign trk_clr        = ~active | ~((phase == PH_CHARGE) | (phase == PH_DRAIN));

    hbwd_sync #(
        .LANES  (HB_LANES),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk    (clk),
        .rst    (rst),
        .raw_i  (hb_raw),
        .rise_o (hb_rise)
    );

    hbwd_alt u_alt (
        .clk      (clk),
        .rst      (rst),
        .clr_i    (trk_clr),
        .rise_a_i (hb_rise[LANE_A]),
        .rise_b_i (hb_rise[LANE_B]),
        .done_o   (kick)
    );

    hbwd_phase #(
        .CHARGE_CYC (CHARGE_CYC),
        .DRAIN_CYC  (DRAIN_CYC)
    ) u_phase (
        .clk       (clk),
        .rst       (rst),
        .active_i  (active),
        .done_i    (kick),
        .phase_o   (phase),
        .timeout_o (timeout_o)
    );

endmodule

// File: tb/sim_dual_hb_watchdog.sv
module sim_dual_hb_watchdog;

    localparam int CLK_PERIOD = 10;
    localparam int CHG = 8;
    localparam int DRN = 16;
    localparam int FULL = CHG + DRN + 1;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic hb_a = 1'b0;
    logic hb_b = 1'b0;
    logic inhibit = 1'b0;
    logic mon_en = 1'b0;
    logic timeout;

    int checks = 0;
    int errors = 0;
    int to_seen = 0;
    bit cmp_en = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dual_hb_watchdog #(
        .CHARGE_CYC (CHG),
        .DRAIN_CYC  (DRN)
    ) u0 (
        .clk       (clk),
        .rst       (rst),
        .hb_a_i    (hb_a),
        .hb_b_i    (hb_b),
        .inhibit_i (inhibit),
        .mon_en_i  (mon_en),
        .timeout_o (timeout)
    );

    // Behavioural reference: phase 0 idle, 1 charge, 2 discharge, 3 expired.
    logic [3:0] hist_a = '0;
    logic [3:0] hist_b = '0;
    int m_phase = 0;
    int m_cnt = 0;
    int m_want_b = 0;
    int m_to = 0;
    bit m_ea, m_eb, m_act, m_clr, m_done;

    always @(posedge clk) begin
        if (rst) begin
            hist_a = '0; hist_b = '0;
            m_phase = 0; m_cnt = 0; m_want_b = 0; m_to = 0;
        end else begin
            hist_a = {hist_a[2:0], hb_a};
            hist_b = {hist_b[2:0], hb_b};
            m_ea   = hist_a[2] && !hist_a[3];
            m_eb   = hist_b[2] && !hist_b[3];
            m_act  = mon_en && !inhibit;
            m_clr  = !m_act || !(m_phase == 1 || m_phase == 2);
            m_done = !m_clr && m_want_b == 1 && m_eb;
            m_to   = 0;
            if (!m_act) begin
                m_phase = 0; m_cnt = 0;
            end else if (m_phase == 0) begin
                m_phase = 1; m_cnt = 0;
            end else if (m_phase == 1) begin
                if (m_cnt == CHG - 1) begin m_phase = 2; m_cnt = 0; end
                else m_cnt++;
            end else if (m_phase == 2) begin
                if (m_done) begin m_phase = 1; m_cnt = 0; end
                else if (m_cnt == DRN - 1) begin m_phase = 3; m_cnt = 0; m_to = 1; end
                else m_cnt++;
            end
            if (m_clr) m_want_b = 0;
            else if (m_want_b == 0 && m_ea) m_want_b = 1;
            else if (m_want_b == 1 && m_eb) m_want_b = 0;
        end
    end

    always @(negedge clk) begin
        if (cmp_en) begin
            checks++;
            if (timeout !== (m_to != 0)) begin
                errors++;
                $display("FAIL R3 R4 per-cycle timeout act=%0b exp=%0b at %0t",
                         timeout, (m_to != 0), $time);
            end
            if (timeout === 1'b1) to_seen++;
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse(input bit a, input bit b);
        hb_a = a; hb_b = b;
        step(2);
        hb_a = 1'b0; hb_b = 1'b0;
        step(2);
    endtask

    task automatic restart();
        mon_en = 1'b0;
        step(3);
        mon_en = 1'b1;
    endtask

    task automatic cycles_to_timeout(output int k);
        k = 0;
        do begin
            step(1);
            k++;
        end while (timeout !== 1'b1 && k < 300);
    endtask

    initial begin
        int k, base;
        step(3);
        check(timeout === 1'b0, "R1 timeout during reset", int'(timeout), 0);
        rst = 1'b0;
        cmp_en = 1'b1;
        step(6);
        check(timeout === 1'b0 && to_seen == 0, "R1 quiet with monitor disabled", to_seen, 0);

        // R3 plain expiry timing and pulse width
        restart();
        cycles_to_timeout(k);
        check(k == FULL, "R3 cycles to timeout", k, FULL);
        step(1);
        check(timeout === 1'b0, "R3 pulse one cycle wide", int'(timeout), 0);
        base = to_seen;
        step(40);
        check(to_seen == base, "R8 expired stays silent", to_seen, base);

        // R4 steady alternating heartbeat
        restart();
        base = to_seen;
        repeat (12) begin pulse(1, 0); step(2); pulse(0, 1); step(2); end
        check(to_seen == base, "R4 alternating heartbeat keeps alive", to_seen, base);

        // R2 held levels count once
        restart();
        hb_a = 1'b1; hb_b = 1'b1;
        cycles_to_timeout(k);
        check(k == FULL, "R2 held levels do not kick", k, FULL);
        hb_a = 1'b0; hb_b = 1'b0;

        // R5 B only, repeated A, reversed order
        restart();
        base = to_seen;
        repeat (8) pulse(0, 1);
        check(to_seen == base + 1, "R5 B-only train times out", to_seen, base + 1);
        restart();
        base = to_seen;
        repeat (8) pulse(1, 0);
        check(to_seen == base + 1, "R5 repeated A times out", to_seen, base + 1);
        restart();
        step(CHG + 2);
        pulse(0, 1);
        pulse(1, 0);
        cycles_to_timeout(k);
        check(k + CHG + 10 == FULL, "R5 B then A is no kick", k + CHG + 10, FULL);

        // R6 simultaneous edges
        restart();
        pulse(1, 1);
        cycles_to_timeout(k);
        check(k + 4 == FULL, "R6 tie alone is no kick", k + 4, FULL);
        restart();
        base = to_seen;
        step(CHG + 2);
        pulse(1, 1);
        pulse(0, 1);
        step(12);
        check(to_seen == base, "R6 tie then B kicks", to_seen, base);

        // R9 tied heartbeat
        restart();
        base = to_seen;
        repeat (16) begin hb_a = 1'b1; hb_b = 1'b1; step(2); hb_a = 1'b0; hb_b = 1'b0; step(4); end
        check(to_seen == base, "R9 tied period 6 survives", to_seen, base);
        restart();
        base = to_seen;
        repeat (6) begin hb_a = 1'b1; hb_b = 1'b1; step(2); hb_a = 1'b0; hb_b = 1'b0; step(12); end
        check(to_seen == base + 1, "R9 tied period 14 times out", to_seen, base + 1);

        // R7 inhibit
        restart();
        step(CHG + 4);
        inhibit = 1'b1;
        base = to_seen;
        step(60);
        check(to_seen == base, "R7 no timeout while inhibited", to_seen, base);
        inhibit = 1'b0;
        cycles_to_timeout(k);
        check(k == FULL, "R7 restart from charge after inhibit", k, FULL);

        // R10 last-cycle kick versus one cycle late
        restart();
        base = to_seen;
        step(CHG + 2);
        pulse(1, 0);
        step(CHG + DRN - 2 - (CHG + 6));
        hb_b = 1'b1; step(2); hb_b = 1'b0;
        step(10);
        check(to_seen == base, "R10 kick on last cycle wins", to_seen, base);
        restart();
        base = to_seen;
        step(CHG + 2);
        pulse(1, 0);
        step(CHG + DRN - 1 - (CHG + 6));
        hb_b = 1'b1; step(2); hb_b = 1'b0;
        step(10);
        check(to_seen == base + 1, "R10 kick one cycle late", to_seen, base + 1);

        // R1 reset in mid-run
        restart();
        step(CHG + 3);
        rst = 1'b1;
        step(2);
        check(timeout === 1'b0, "R1 reset mid-run", int'(timeout), 0);
        rst = 1'b0;
        step(4);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        checks++;
        errors++;
        $display("FAIL R3 watchdog expired act=0 exp=1");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule